// File: doc/BRIEF.md
# Serial GPIO Clock and Frame Timer

This block sits at the front of a serial GPIO master. It holds one 32-bit control word, written and read through a plain register port. From a fast peripheral clock it derives a slow serial shift clock and the slot timing of the frame that a separate shift data path uses. A frame holds a programmed number of serial pin slots. The pin count is always a multiple of eight and each slot moves one input bit and one output bit. The block reports which slot is active and marks the first slot of every frame with a load strobe.

The control word holds three things. The divider field sets the serial clock period to twice (divider + 1) peripheral cycles. The count field holds the number of pins divided by eight. The enable bit starts and stops everything. A build parameter selects the width of the count field: a narrow variant with four bits or a wide variant with five. Every bit the selected variant does not implement is dropped when written. The register port has no stream traffic and no back-pressure. A write takes effect at the clock edge where the write enable is sampled high, and read data always shows the current word.

Top module: `sgpio_frame_ctl`

## Requirements
- R1: After reset the control word reads 0 and all outputs are low or zero. A write stores only the implemented bits: the divider in bits 31:16, the count field, and the enable in bit 0. Every other bit reads back as 0.
- R2: The count field starts at bit 6. It is 4 bits wide (bits 9:6) when WIDE_CNT=0 and 5 bits wide (bits 10:6) when WIDE_CNT=1.
- R3: The edge that stores a running configuration with divider D starts the serial clock low. The clock then stays low for D+1 cycles and high for D+1 cycles, so its period is 2×(D+1) peripheral cycles.
- R4: The slot index starts at 0 and advances by one on every falling edge of the serial clock. After slot 8×count−1 it wraps back to 0.
- R5: The frame load strobe is high exactly while the block runs and the slot index is 0. This makes it one serial clock period wide at the start of each frame.
- R6: A write that clears the enable parks the serial clock low and resets the slot index to 0 by the second sampling point after the write edge. The load strobe drops at once.
- R7: With a count field of zero, the serial clock, load strobe and slot index stay idle even when the enable is set.
- R8: Enabling again after a stop restarts the timing from phase 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Current control word |
| sclk_o | output | 1 | Serial shift clock |
| frame_load_o | output | 1 | High during the first slot of each frame |
| slot_idx_o | output | CNT_W+3 | Active slot index |

## Verification
The hardest case to reach is the last slot of the longest frame wrapping to slot 0. The stimulus reaches it by programming the maximum count with divider 0 and checking every cycle across two whole frames against a closed-form phase and slot formula. The second hard case is a stop issued while the serial clock is high in the middle of a frame. The bench stops the run at a cycle it has computed to be in the high half, confirms the clock is high there, and then checks the park and the restart.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int DIV_LSB = 16;
  localparam int DIV_W   = 16;
  localparam int CNT_LSB = 6;
  localparam int EN_BIT  = 0;

  function automatic logic [31:0] ctrl_mask(input int cnt_w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < DIV_W; i++) m[DIV_LSB + i] = 1'b1;
    for (int i = 0; i < cnt_w; i++) m[CNT_LSB + i] = 1'b1;
    m[EN_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sgc_ctrl_reg.sv
module sgc_ctrl_reg
  import sgc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       ctrl_o,
  output logic              en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [31:0] WMASK = ctrl_mask(CNT_W);

  logic [31:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & WMASK;
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = ctrl_q[EN_BIT];
  assign div_o  = ctrl_q[DIV_LSB +: DIV_W];
  assign cnt_o  = ctrl_q[CNT_LSB +: CNT_W];

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/sgc_clk_div.sv
module sgc_clk_div
  import sgc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             at_end;

  assign at_end = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o      = sclk_q;
  assign fall_tick_o = run_i & sclk_q & at_end;

  assert_park_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!sclk_o && cnt_q == '0));
  assert_tick_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_tick_o |=> $fell(sclk_o));
endmodule

// File: rtl/sgc_frame_seq.sv
module sgc_frame_seq #(
  parameter int CNT_W = 4,
  localparam int IDX_W = CNT_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = {cnt_i, 3'b000} - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (!run_i)          idx_q <= '0;
    else if (tick_i) begin
      if (idx_q >= last_idx)  idx_q <= '0;
      else                    idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign load_o = run_i & (idx_q == '0);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(idx_q));
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (idx_q == '0));
endmodule

// File: rtl/sgpio_frame_ctl.sv
module sgpio_frame_ctl
  import sgc_pkg::*;
#(
  parameter bit WIDE_CNT = 1'b0,
  localparam int CNT_W = WIDE_CNT ? 5 : 4,
  localparam int IDX_W = CNT_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  output logic             sclk_o,
  output logic             frame_load_o,
  output logic [IDX_W-1:0] slot_idx_o
);
  logic             en;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             fall_tick;

  sgc_ctrl_reg #(.CNT_W(CNT_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ctrl_o  (cfg_rdata_o),
    .en_o    (en),
    .div_o   (div),
    .cnt_o   (cnt)
  );

  assign run = en & (cnt != '0);

  sgc_clk_div u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .div_i       (div),
    .sclk_o      (sclk_o),
    .fall_tick_o (fall_tick)
  );

  sgc_frame_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (fall_tick),
    .cnt_i  (cnt),
    .idx_o  (slot_idx_o),
    .load_o (frame_load_o)
  );

  assert_zero_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[CNT_LSB +: CNT_W] == '0) |=> !sclk_o);
endmodule

// File: tb/sgpio_frame_ctl_tb_top.sv
module sgpio_frame_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic        sclk, sclk_w, load, load_w;
  logic [6:0]  idx;
  logic [7:0]  idx_w;
  int vectors = 0;
  int errors  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sgpio_frame_ctl #(.WIDE_CNT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .sclk_o(sclk), .frame_load_o(load), .slot_idx_o(idx));

  sgpio_frame_ctl #(.WIDE_CNT(1'b1)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata_w), .sclk_o(sclk_w), .frame_load_o(load_w), .slot_idx_o(idx_w));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Caller is at a negedge; returns at the negedge after the write edge (t=0).
  task automatic write_ctrl(input logic [31:0] v);
    we = 1'b1; wdata = v;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] cfg(input int d, input int c, input bit en);
    return (32'(d) << 16) | (32'(c) << 6) | 32'(en);
  endfunction

  task automatic run_and_check(input int d, input int c, input int cycles, input string req);
    int half = d + 1;
    int per  = 2 * half;
    int n    = 8 * c;
    for (int t = 0; t < cycles; t++) begin
      int ph  = t % per;
      int sl  = (t / per) % n;
      chk(req, "sclk", longint'(sclk), longint'(ph >= half));
      chk(req, "slot", longint'(idx), longint'(sl));
      chk(req, "load", longint'(load), longint'(sl == 0));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1", "rdata reset", rdata, 0);
    chk("R1", "sclk reset", sclk, 0);
    chk("R1", "load reset", load, 0);
    chk("R1", "slot reset", idx, 0);
  endtask

  task automatic t_mask;
    write_ctrl(32'hFFFF_FFFE);
    chk("R1", "narrow readback", rdata, 32'hFFFF_03C0);
    chk("R2", "wide readback", rdata_w, 32'hFFFF_07C0);
    write_ctrl(32'h0000_0440);
    chk("R2", "narrow drops bit10", rdata, 32'h0000_0040);
    chk("R2", "wide keeps bit10", rdata_w, 32'h0000_0440);
    write_ctrl(32'h0);
    chk("R1", "cleared", rdata, 0);
  endtask

  task automatic t_basic;
    write_ctrl(cfg(0, 1, 1'b1));
    run_and_check(0, 1, 48, "R3 R4 R5 div0");
    write_ctrl(32'h0);
    @(negedge clk);
    write_ctrl(cfg(2, 2, 1'b1));
    run_and_check(2, 2, 192, "R3 R4 R5 div2");
    write_ctrl(32'h0);
    @(negedge clk);
  endtask

  task automatic t_stop_restart;
    write_ctrl(cfg(2, 1, 1'b1));
    run_and_check(2, 1, 4, "R3 pre-stop");
    chk("R6", "sclk high before stop", sclk, 1);
    write_ctrl(cfg(2, 1, 1'b0));
    chk("R6", "load drops", load, 0);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk("R6", "sclk parked", sclk, 0);
      chk("R6", "slot reset", idx, 0);
      chk("R6", "load low", load, 0);
      @(negedge clk);
    end
    write_ctrl(cfg(2, 1, 1'b1));
    run_and_check(2, 1, 60, "R8 restart");
    write_ctrl(32'h0);
    @(negedge clk);
  endtask

  task automatic t_zero_count;
    write_ctrl(cfg(0, 0, 1'b1));
    for (int k = 0; k < 40; k++) begin
      chk("R7", "sclk idle", sclk, 0);
      chk("R7", "load idle", load, 0);
      chk("R7", "slot idle", idx, 0);
      @(negedge clk);
    end
    write_ctrl(32'h0);
    @(negedge clk);
  endtask

  task automatic t_max_frame;
    write_ctrl(cfg(0, 15, 1'b1));
    run_and_check(0, 15, 2 * 240 + 4, "R4 R5 max wrap");
    write_ctrl(cfg(1, 1, 1'b1));
    write_ctrl(32'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_basic;
    t_stop_restart;
    t_zero_count;
    t_max_frame;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule